// File: doc/BRIEF.md
# Cascadable Configuration Stream Reader

This block reads a preloaded configuration image out of an internal byte array and hands it to an FPGA, one element per configuration clock. An internal address counter moves forward on each rising clock edge while the block is selected and out of reset. In serial mode each byte is sent as eight bits on data line 0, most significant bit first. In parallel mode a whole byte is sent on data lines 7..0 at each clock. A mode input selects between the two. It is driven from a control register outside the block, and low means serial.

Several readers can share one clock and one set of data lines. Each reader's chain-enable output drives the select input of the next reader in the chain. When a reader passes its last address it stops counting, releases the data lines and pulls its chain-enable output low, all on the same clock edge. The next reader then drives the lines with no gap and no overlap. An active-low output-enable/reset input clears every reader in the chain. A high select input puts a reader into standby and also clears its counter.

Top module: `cfg_stream_reader`

## Requirements
- R1: While `oe_rst_n` is low, `data_oe` is 0 and `ceo_n` is 1, and the counter is cleared at once. When `oe_rst_n` goes high with `ce_n` low, the output shows byte 0 (bit 7 of byte 0 in serial mode).
- R2: A rising edge with `ce_n` high clears the counter. While `ce_n` is high, `data_oe` is 0 and `ceo_n` is 1, whatever the level of `oe_rst_n`.
- R3: In parallel mode (`par_mode`=1), `data_oe`=8'hFF, and `data_o` carries image byte n. Each rising edge with `ce_n` low and `oe_rst_n` high moves n up by one.
- R4: In serial mode (`par_mode`=0), `data_oe`=8'h01 and `data_o[7:1]`=0. `data_o[0]` carries the bits of byte n in order 7 down to 0, one bit per edge, and n moves up after every eighth edge.
- R5: The rising edge that consumes the last element (byte LAST_ADDR in parallel mode, bit 0 of byte LAST_ADDR in serial mode) sets `data_oe` to 0 and `ceo_n` to 0 in the same step. After that, further edges change nothing.
- R6: `ceo_n` is 0 only while `ce_n` is 0, `oe_rst_n` is 1 and the counter is past the last address. In every other state it is 1.
- R7: After a handoff, pulling `oe_rst_n` low raises `ceo_n`. It stays 1 through any number of edges until `oe_rst_n` returns high. At that point the reader restarts at byte 0 and keeps `ceo_n` at 1.
- R8: Byte i of the image is `IMAGE[8*i +: 8]`, for i from 0 to LAST_ADDR.
- R9: Two readers chained by `ceo_n` to `ce_n` produce the first image followed by the second on the shared lines. The stream has no gap, no repeated element, and never has both readers driving at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; counter advances on its rising edge |
| ce_n | input | 1 | Active-low select; high gives standby and clears the counter |
| oe_rst_n | input | 1 | Active-low output enable / asynchronous counter reset |
| par_mode | input | 1 | 0 = serial on line 0, 1 = byte-wide parallel |
| data_o | output | 8 | Data value for each line |
| data_oe | output | 8 | Per-line drive enable (0 = high impedance) |
| ceo_n | output | 1 | Chain-enable output to the next reader's `ce_n` |

## Verification
The assertions assume that `par_mode` is held steady through a stream and is changed only while the reader is in reset or standby. They also assume that `ce_n` and `oe_rst_n` change away from the rising clock edge, so each edge samples a settled level. The stimulus changes every input one time unit after a rising edge, and it sets the mode only at the start of each scenario, before reset is released. Every output check is taken at that same point, after the state and the output logic have settled.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BIT_IDX_W = 3;

    typedef enum logic {
        MODE_SERIAL   = 1'b0,
        MODE_PARALLEL = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/cfg_image_rom.sv
module cfg_image_rom #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4,
    parameter logic [8*DEPTH-1:0] IMAGE = '0
) (
    input  logic [AW-1:0] addr_i,
    output logic [7:0]    rd_byte_o
);
    always_comb begin
        rd_byte_o = IMAGE[int'(addr_i)*8 +: 8];
    end
endmodule

// File: rtl/cfg_read_seq.sv
module cfg_read_seq
    import cfg_rd_pkg::*;
#(
    parameter int unsigned LAST_ADDR = 15,
    parameter int unsigned AW        = 4
) (
    input  logic                 clk,
    input  logic                 oe_rst_n,
    input  logic                 ce_n,
    input  logic                 par_mode,
    output logic [AW-1:0]        addr_o,
    output logic [BIT_IDX_W-1:0] bitsel_o,
    output logic                 past_tc_o
);
    localparam logic [AW-1:0]        TC_ADDR  = AW'(LAST_ADDR);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = '1;

    typedef struct packed {
        logic [AW-1:0]        addr;
        logic [BIT_IDX_W-1:0] bitsel;
        logic                 past_tc;
    } seq_t;

    seq_t st_d, st_q;
    logic unit_done;

    always_comb begin
        st_d      = st_q;
        unit_done = (par_mode == MODE_PARALLEL) || (st_q.bitsel == LAST_BIT);
        if (ce_n) begin
            st_d = '0;
        end else if (!st_q.past_tc) begin
            if (par_mode == MODE_SERIAL) begin
                st_d.bitsel = st_q.bitsel + 1'b1;
            end
            if (unit_done) begin
                if (st_q.addr == TC_ADDR) begin
                    st_d.past_tc = 1'b1;
                end else begin
                    st_d.addr = st_q.addr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge oe_rst_n) begin
        if (!oe_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = st_q.addr;
    assign bitsel_o  = st_q.bitsel;
    assign past_tc_o = st_q.past_tc;
endmodule

// File: rtl/cfg_pin_drive.sv
module cfg_pin_drive
    import cfg_rd_pkg::*;
(
    input  logic                 ce_n,
    input  logic                 oe_rst_n,
    input  logic                 par_mode,
    input  logic                 past_tc,
    input  logic [7:0]           rd_byte,
    input  logic [BIT_IDX_W-1:0] bitsel,
    output logic [7:0]           data_o,
    output logic [7:0]           data_oe,
    output logic                 ceo_n
);
    logic live;
    logic drive;

    always_comb begin
        live  = !ce_n && oe_rst_n;
        drive = live && !past_tc;
        ceo_n = !(live && past_tc);
        if (par_mode == MODE_PARALLEL) begin
            data_oe = {8{drive}};
            data_o  = drive ? rd_byte : 8'h00;
        end else begin
            data_oe = {7'b0, drive};
            data_o  = {7'b0, drive & rd_byte[3'd7 - bitsel]};
        end
    end
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfg_rd_pkg::*;
#(
    parameter int unsigned LAST_ADDR = 15,
    parameter logic [8*(LAST_ADDR+1)-1:0] IMAGE = {(LAST_ADDR+1){8'h5A}}
) (
    input  logic       clk,
    input  logic       ce_n,
    input  logic       oe_rst_n,
    input  logic       par_mode,
    output logic [7:0] data_o,
    output logic [7:0] data_oe,
    output logic       ceo_n
);
    localparam int unsigned DEPTH = LAST_ADDR + 1;
    localparam int unsigned AW    = (DEPTH > 2) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]        addr;
    logic [BIT_IDX_W-1:0] bitsel;
    logic                 past_tc;
    logic [7:0]           rd_byte;

    cfg_read_seq #(
        .LAST_ADDR (LAST_ADDR),
        .AW        (AW)
    ) u_seq (
        .clk       (clk),
        .oe_rst_n  (oe_rst_n),
        .ce_n      (ce_n),
        .par_mode  (par_mode),
        .addr_o    (addr),
        .bitsel_o  (bitsel),
        .past_tc_o (past_tc)
    );

    cfg_image_rom #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .IMAGE (IMAGE)
    ) u_rom (
        .addr_i    (addr),
        .rd_byte_o (rd_byte)
    );

    cfg_pin_drive u_pins (
        .ce_n     (ce_n),
        .oe_rst_n (oe_rst_n),
        .par_mode (par_mode),
        .past_tc  (past_tc),
        .rd_byte  (rd_byte),
        .bitsel   (bitsel),
        .data_o   (data_o),
        .data_oe  (data_oe),
        .ceo_n    (ceo_n)
    );
endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk (
    input logic       clk,
    input logic       ce_n,
    input logic       oe_rst_n,
    input logic       par_mode,
    input logic [7:0] data_oe,
    input logic       ceo_n
);
    // R1: reset forces outputs off and the chain output high
    always @(posedge clk) begin
        if (!oe_rst_n) begin
            assert_reset_quiet_R1: assert (data_oe == 8'h00 && ceo_n);
        end
    end

    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!oe_rst_n)
        ce_n |-> (data_oe == 8'h00 && ceo_n));

    assert_serial_one_line_R4: assert property (@(posedge clk) disable iff (!oe_rst_n)
        !par_mode |-> (data_oe[7:1] == 7'b0));

    assert_handoff_releases_R5: assert property (@(posedge clk) disable iff (!oe_rst_n)
        !ceo_n |-> (data_oe == 8'h00));

    assert_handoff_sticks_R5: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (!ceo_n && !ce_n) |=> (ce_n || !ceo_n));

    assert_chain_needs_select_R6: assert property (@(posedge clk) disable iff (!oe_rst_n)
        !ceo_n |-> !ce_n);
endmodule

bind cfg_stream_reader cfg_stream_reader_chk u_chk (
    .clk      (clk),
    .ce_n     (ce_n),
    .oe_rst_n (oe_rst_n),
    .par_mode (par_mode),
    .data_oe  (data_oe),
    .ceo_n    (ceo_n)
);

// File: tb/sim_cfg_stream_reader.sv
`timescale 1ns/1ps
module sim_cfg_stream_reader;
    localparam int unsigned LAST  = 7;
    localparam int unsigned DEPTH = LAST + 1;

    function automatic logic [8*DEPTH-1:0] mk_img(input logic [7:0] seed);
        logic [8*DEPTH-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) begin
            v[8*i +: 8] = (seed + 8'(i * 37)) ^ 8'(i << 3);
        end
        return v;
    endfunction

    localparam logic [8*DEPTH-1:0] IMG_A = mk_img(8'h3C);
    localparam logic [8*DEPTH-1:0] IMG_B = mk_img(8'hC5);

    logic       clk = 1'b0;
    logic       ce_n = 1'b1;
    logic       oe_rst_n = 1'b0;
    logic       par_mode = 1'b0;
    logic [7:0] d0, e0, d1, e1;
    logic       ceo0, ceo1;
    int         checks = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    cfg_stream_reader #(.LAST_ADDR(LAST), .IMAGE(IMG_A)) u0 (
        .clk(clk), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .par_mode(par_mode),
        .data_o(d0), .data_oe(e0), .ceo_n(ceo0));

    cfg_stream_reader #(.LAST_ADDR(LAST), .IMAGE(IMG_B)) u1 (
        .clk(clk), .ce_n(ceo0), .oe_rst_n(oe_rst_n), .par_mode(par_mode),
        .data_o(d1), .data_oe(e1), .ceo_n(ceo1));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] img_byte(input logic [8*DEPTH-1:0] img, input int i);
        return img[8*i +: 8];
    endfunction

    task automatic start(input logic mode);
        par_mode = mode;
        oe_rst_n = 1'b0;
        ce_n     = 1'b1;
        tick();
        oe_rst_n = 1'b1;
        ce_n     = 1'b0;
        #1;
    endtask

    task automatic t_reset_state;
        par_mode = 1'b1;
        oe_rst_n = 1'b0;
        ce_n     = 1'b0;
        tick();
        chk(e0 == 8'h00 && e1 == 8'h00, "R1 enables off in reset", {e0, e1}, 0);
        chk(ceo0 && ceo1, "R1 chain high in reset", {ceo0, ceo1}, 2'b11);
        oe_rst_n = 1'b1;
        #1;
        chk(e0 == 8'hFF && d0 == img_byte(IMG_A, 0), "R1 first byte after release", d0, img_byte(IMG_A, 0));
    endtask

    task automatic t_stream(input logic mode);
        int per_dev;
        int total;
        logic [7:0] exp;
        logic [7:0] act;
        logic [7:0] en_exp;
        per_dev = mode ? DEPTH : DEPTH * 8;
        total   = 2 * per_dev;
        en_exp  = mode ? 8'hFF : 8'h01;
        start(mode);
        for (int k = 0; k < total; k++) begin
            int dev;
            int item;
            dev  = k / per_dev;
            item = k % per_dev;
            if (mode) begin
                exp = img_byte(dev ? IMG_B : IMG_A, item);
            end else begin
                exp = {7'b0, img_byte(dev ? IMG_B : IMG_A, item / 8)[7 - (item % 8)]};
            end
            chk(!(e0 != 0 && e1 != 0), "R9 single driver", {e0, e1}, 0);
            if (dev == 0) begin
                act = d0;
                chk(e0 == en_exp, mode ? "R3 parallel enables" : "R4 serial enables", e0, en_exp);
            end else begin
                act = d1;
                chk(e1 == en_exp, mode ? "R3 parallel enables" : "R4 serial enables", e1, en_exp);
            end
            if (k == per_dev - 1) chk(ceo0 == 1'b1, "R6 chain high before last consumed", ceo0, 1);
            if (k == per_dev)     chk(ceo0 == 1'b0 && e0 == 0, "R5 handoff step", {ceo0, e0}, 0);
            chk(act == exp, mode ? "R8 R9 parallel stream" : "R4 R9 serial stream", act, exp);
            tick();
        end
        chk(e0 == 0 && e1 == 0, "R5 all released at end", {e0, e1}, 0);
        chk(!ceo0 && !ceo1, "R6 chain low past terminal count", {ceo0, ceo1}, 0);
    endtask

    task automatic t_freeze;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(e0 == 0 && e1 == 0 && !ceo1, "R5 frozen after terminal count", {e0, e1, 7'b0, ceo1}, 0);
        end
    endtask

    task automatic t_reset_midstream;
        start(1'b1);
        for (int i = 0; i < 3; i++) tick();
        chk(d0 == img_byte(IMG_A, 3), "R3 advanced three bytes", d0, img_byte(IMG_A, 3));
        oe_rst_n = 1'b0;
        #1;
        chk(e0 == 0 && e1 == 0 && ceo0 && ceo1, "R1 mid-stream reset quiet", {e0, e1, 6'b0, ceo0, ceo1}, 3);
        tick();
        tick();
        oe_rst_n = 1'b1;
        #1;
        chk(d0 == img_byte(IMG_A, 0) && e0 == 8'hFF, "R1 restart at byte 0", d0, img_byte(IMG_A, 0));
    endtask

    task automatic t_serial_reset;
        start(1'b0);
        for (int i = 0; i < 11; i++) tick();
        chk(d0[0] == img_byte(IMG_A, 1)[4], "R4 byte advance after eight bits", d0[0], img_byte(IMG_A, 1)[4]);
        oe_rst_n = 1'b0;
        #1;
        oe_rst_n = 1'b1;
        #1;
        chk(d0[0] == img_byte(IMG_A, 0)[7] && e0 == 8'h01, "R1 serial restart MSB of byte 0", d0[0], img_byte(IMG_A, 0)[7]);
    endtask

    task automatic t_standby;
        start(1'b1);
        for (int i = 0; i < 4; i++) tick();
        ce_n = 1'b1;
        #1;
        chk(e0 == 0 && ceo0 && e1 == 0, "R2 standby quiet", {e0, e1, 7'b0, ceo0}, 1);
        tick();
        chk(e0 == 0 && ceo0, "R2 standby held across edge", {e0, 7'b0, ceo0}, 1);
        oe_rst_n = 1'b0;
        #1;
        oe_rst_n = 1'b1;
        #1;
        chk(e0 == 0 && ceo0, "R2 standby wins over enable", {e0, 7'b0, ceo0}, 1);
        ce_n = 1'b0;
        #1;
        chk(d0 == img_byte(IMG_A, 0), "R2 counter cleared by standby", d0, img_byte(IMG_A, 0));
        for (int i = 0; i < DEPTH; i++) tick();
        chk(!ceo0, "R6 chain low at end", ceo0, 0);
        ce_n = 1'b1;
        #1;
        chk(ceo0, "R6 chain high once deselected", ceo0, 1);
    endtask

    task automatic t_oe_after_handoff;
        start(1'b1);
        for (int i = 0; i < DEPTH; i++) tick();
        chk(!ceo0, "R7 handoff reached", ceo0, 0);
        oe_rst_n = 1'b0;
        #1;
        chk(ceo0, "R7 chain high in reset", ceo0, 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(ceo0, "R7 chain stays high", ceo0, 1);
        end
        oe_rst_n = 1'b1;
        #1;
        chk(ceo0 && e0 == 8'hFF && d0 == img_byte(IMG_A, 0), "R7 restart after release", d0, img_byte(IMG_A, 0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_stream(1'b1);
        t_freeze();
        t_stream(1'b0);
        t_freeze();
        t_reset_midstream();
        t_serial_reset();
        t_standby();
        t_oe_after_handoff();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule